// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block runs one external bus machine cycle for a small 8-bit processor core. The low address byte and the data share a single set of lines. A core-side request brings a 16-bit address, a direction flag, an address-space flag (memory or I/O) and a write byte. The sequencer moves through one T-state per clock. In the first T-state it places the low address byte on the shared lines and pulses an address-latch strobe, so an external latch can hold that byte for the rest of the cycle. It then asserts a read or write strobe and samples a ready input. While ready is low it adds wait states. A final T-state completes the transfer.

States and transitions: `ST_IDLE` goes to `ST_T1` when a request is present. `ST_T1` always goes to `ST_T2`. `ST_T2` goes to `ST_T3` when ready is high and to `ST_TW` when it is low. `ST_TW` stays in `ST_TW` while ready is low and goes to `ST_T3` once it is high. `ST_T3` always returns to `ST_IDLE`.

The upper address byte is held for the whole cycle. For an I/O access only the 8-bit port number is meaningful, and it appears on both the shared lines and the upper address lines. After `ST_T3` the block returns read data and gives a one-clock completion pulse. A new request can be taken in that same clock.

Top module: `mbus_cycle_seq`

## Requirements
- R1: While reset is held and while idle, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `busy`=0 and `done`=0. Reset is asynchronous and active low, and it abandons a cycle in progress.
- R2: One clock after a request is accepted, the block is in T1 for exactly one clock. In T1, `ale`=1, `ad_oe`=1 and `ad_out` equals the low address byte. `ale` is 0 in every other state.
- R3: From T1 through T3, `a_hi` carries address bits 15..8 for a memory access. For an I/O access it carries a copy of address bits 7..0, and address bits 15..8 are ignored.
- R4: From T1 through T3, `io_m` is 0 for a memory access and 1 for an I/O access, and it is stable throughout.
- R5: A read drives `rd_n` low and a write drives `wr_n` low, from T2 through T3. The two strobes are never low together, and both are high in T1.
- R6: If `bus_ready` is low when sampled in T2 or in a wait state, one more wait state follows, with the strobe held. With n low samples the strobe stays low for n+2 clocks, and the whole cycle from T1 to T3 lasts n+3 clocks.
- R7: In a read, `ad_oe` is 0 from T2 through T3, and `rdata` takes the value of `ad_in` at the clock edge that ends T3.
- R8: In a write, `ad_oe`=1 and `ad_out` equals the write byte from T2 through T3.
- R9: `done` is a one-clock pulse in the clock that follows T3, and `rdata` is valid in that clock.
- R10: A request is taken only in idle. `req_valid` is ignored while `busy` is high. A request presented during the completion clock starts T1 in the next clock.
- R11: `busy` is 1 from T1 through T3 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted only when idle |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | A machine cycle is in progress |
| bus_ready | input | 1 | Device ready; low inserts wait states |
| ad_in | input | 8 | Value seen on the shared lines |
| ad_out | output | 8 | Value driven onto the shared lines |
| ad_oe | output | 1 | Shared-line output enable |
| a_hi | output | 8 | Upper address lines |
| ale | output | 1 | Address-latch strobe, high in T1 |
| io_m | output | 1 | Address space: 0 memory, 1 I/O |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rdata | output | 8 | Byte captured at the end of a read |
| done | output | 1 | One-clock completion pulse |

## Verification
A corrupted state register shows at the strobes within one clock. A stuck or skipped T-state either gives a second `ale` pulse or a strobe window whose length differs from n+2. A transition that ignores ready ends the cycle early, so `done` arrives before the bench has released ready. A wrong held request field appears as a wrong `a_hi`, `io_m` or write byte during the strobe window, or as a wrong `rdata` one clock after T3.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // T-states of one external machine cycle
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4
    } tstate_e;

endpackage

// File: rtl/mbus_tstate_fsm.sv
module mbus_tstate_fsm
    import mbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    bus_ready,
    output tstate_e state_q,
    output logic    load_req,
    output logic    end_of_t3
);

    tstate_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = bus_ready ? ST_T3 : ST_TW;
            ST_TW:   state_d = bus_ready ? ST_T3 : ST_TW;
            ST_T3:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign load_req  = (state_q == ST_IDLE) && req_valid;
    assign end_of_t3 = (state_q == ST_T3);

endmodule

// File: rtl/mbus_req_hold.sv
module mbus_req_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              write_in,
    input  logic              io_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic              write_q,
    output logic              io_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Request fields held for the whole machine cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            io_q    <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= addr_in;
            write_q <= write_in;
            io_q    <= io_in;
            wdata_q <= wdata_in;
        end
    end

endmodule

// File: rtl/mbus_rd_capture.sv
module mbus_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              end_of_t3,
    input  logic              is_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= end_of_t3;
            if (end_of_t3 && !is_write) begin
                rdata <= ad_in;
            end
        end
    end

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    input  logic                       req_io,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       busy,
    input  logic                       bus_ready,
    input  logic [DATA_W-1:0]          ad_in,
    output logic [DATA_W-1:0]          ad_out,
    output logic                       ad_oe,
    output logic [ADDR_W-DATA_W-1:0]   a_hi,
    output logic                       ale,
    output logic                       io_m,
    output logic                       rd_n,
    output logic                       wr_n,
    output logic [DATA_W-1:0]          rdata,
    output logic                       done
);

    localparam int HI_W = ADDR_W - DATA_W;

    tstate_e           state_q;
    logic              load_req;
    logic              end_of_t3;
    logic [ADDR_W-1:0] addr_q;
    logic              req_wr_q;
    logic              req_io_q;
    logic [DATA_W-1:0] wdata_q;
    logic [HI_W-1:0]   port_hi;
    logic [HI_W-1:0]   hi_src;

    mbus_tstate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .state_q   (state_q),
        .load_req  (load_req),
        .end_of_t3 (end_of_t3)
    );

    mbus_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_req),
        .addr_in  (req_addr),
        .write_in (req_write),
        .io_in    (req_io),
        .wdata_in (req_wdata),
        .addr_q   (addr_q),
        .write_q  (req_wr_q),
        .io_q     (req_io_q),
        .wdata_q  (wdata_q)
    );

    mbus_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_of_t3 (end_of_t3),
        .is_write  (req_wr_q),
        .ad_in     (ad_in),
        .rdata     (rdata),
        .done      (done)
    );

    // I/O port number mirrored onto the upper lines, sized to fit
    generate
        if (HI_W == DATA_W) begin : g_hi_same
            assign port_hi = addr_q[DATA_W-1:0];
        end else if (HI_W > DATA_W) begin : g_hi_wide
            assign port_hi = {{(HI_W-DATA_W){1'b0}}, addr_q[DATA_W-1:0]};
        end else begin : g_hi_narrow
            assign port_hi = addr_q[HI_W-1:0];
        end
    endgenerate

    assign hi_src = req_io_q ? port_hi : addr_q[ADDR_W-1:DATA_W];

    // Output decode per T-state
    always_comb begin
        ale    = 1'b0;
        ad_out = '0;
        ad_oe  = 1'b0;
        a_hi   = '0;
        io_m   = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
                a_hi   = hi_src;
                io_m   = req_io_q;
            end
            ST_T2, ST_TW, ST_T3: begin
                a_hi = hi_src;
                io_m = req_io_q;
                if (req_wr_q) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = wdata_q;
                end else begin
                    rd_n = 1'b0;
                end
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk
    import mbus_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input tstate_e state_q,
    input logic    req_valid,
    input logic    bus_ready,
    input logic    ale,
    input logic    ad_oe,
    input logic    rd_n,
    input logic    wr_n,
    input logic    io_m,
    input logic    busy,
    input logic    done
);

    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_ale_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n));

    assert_io_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(io_m));

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == ST_T2) || (state_q == ST_TW)) && !bus_ready)
            |=> ((state_q == ST_TW) && !done && !(rd_n && wr_n)));

    assert_read_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_write_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && req_valid) |=> ale);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && wr_n && !ale && !ad_oe));

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .req_valid (req_valid),
    .bus_ready (bus_ready),
    .ale       (ale),
    .ad_oe     (ad_oe),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .io_m      (io_m),
    .busy      (busy),
    .done      (done)
);

// File: tb/mbus_cycle_seq_bench.sv
module mbus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic        bus_ready = 1'b1;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  a_hi;
    logic        ale;
    logic        io_m;
    logic        rd_n;
    logic        wr_n;
    logic [7:0]  rdata;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    mbus_cycle_seq u_mbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
        .busy(busy), .bus_ready(bus_ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .io_m(io_m), .rd_n(rd_n),
        .wr_n(wr_n), .rdata(rdata), .done(done)
    );

    // fields: write, io, addr[15:0], wdata[7:0], waits[2:0], read byte[7:0]
    localparam int NV = 8;
    localparam logic [36:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 16'h12A5, 8'h00, 3'd0, 8'h3C},
        {1'b1, 1'b0, 16'h8001, 8'h5A, 3'd0, 8'h00},
        {1'b0, 1'b1, 16'h0047, 8'h00, 3'd1, 8'hC3},
        {1'b1, 1'b1, 16'h00F0, 8'hA5, 3'd2, 8'h00},
        {1'b0, 1'b0, 16'hFFFF, 8'h00, 3'd3, 8'h81},
        {1'b1, 1'b0, 16'h0000, 8'hFF, 3'd4, 8'h00},
        {1'b0, 1'b0, 16'h7E00, 8'h00, 3'd0, 8'h00},
        {1'b0, 1'b1, 16'h1399, 8'h00, 3'd2, 8'h66}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one cycle; returns at the negedge where done is seen (idle state)
    task automatic run_cycle(input bit wr, input bit io, input logic [15:0] addr,
                             input logic [7:0] wd, input int nw,
                             input logic [7:0] rb, input bit inject);
        logic [7:0] hi_exp;
        int k;
        hi_exp = io ? addr[7:0] : addr[15:8];
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr; req_io = io;
        req_wdata = wd;
        @(negedge clk);                           // now T1
        req_valid = 1'b0; req_addr = 16'h0000;
        chk(ale === 1'b1, "R2 ale in T1", ale, 1);
        chk(ad_oe === 1'b1 && ad_out === addr[7:0], "R2 low address in T1", ad_out, addr[7:0]);
        chk(a_hi === hi_exp, "R3 upper lines in T1", a_hi, hi_exp);
        chk(io_m === io, "R4 space flag", io_m, io);
        chk(rd_n === 1'b1 && wr_n === 1'b1, "R5 strobes high in T1", {rd_n, wr_n}, 2'b11);
        chk(busy === 1'b1, "R11 busy in T1", busy, 1);
        k = 0;
        for (int guard = 0; guard < 40; guard++) begin
            @(negedge clk);
            if (done === 1'b1) break;
            k++;
            bus_ready = (k > nw);
            ad_in = rb;
            if (inject && k == 1) begin
                req_valid = 1'b1; req_addr = 16'hBEEF; req_write = ~wr; req_io = ~io;
            end else begin
                req_valid = 1'b0;
            end
            chk(ale === 1'b0, "R2 ale low after T1", ale, 0);
            chk(a_hi === hi_exp && io_m === io, "R3/R4 held upper lines and space",
                {a_hi, io_m}, {hi_exp, io});
            if (wr) begin
                chk(wr_n === 1'b0 && rd_n === 1'b1, "R5 write strobe", {rd_n, wr_n}, 2'b10);
                chk(ad_oe === 1'b1 && ad_out === wd, "R8 write byte driven", ad_out, wd);
            end else begin
                chk(rd_n === 1'b0 && wr_n === 1'b1, "R5 read strobe", {rd_n, wr_n}, 2'b01);
                chk(ad_oe === 1'b0, "R7 lines released in read", ad_oe, 0);
            end
        end
        req_valid = 1'b0;
        ad_in = 8'h00;
        bus_ready = 1'b1;
        chk(done === 1'b1, "R9 done pulse", done, 1);
        chk(k == nw + 2, "R6 strobe window length", k, nw + 2);
        chk(busy === 1'b0 && rd_n === 1'b1 && wr_n === 1'b1, "R11 idle after T3",
            {busy, rd_n, wr_n}, 3'b011);
        if (!wr) chk(rdata === rb, "R7 read byte captured", rdata, rb);
    endtask

    initial begin
        // R1: reset state
        #5;
        chk(ale === 0 && rd_n === 1 && wr_n === 1 && ad_oe === 0 && busy === 0 && done === 0,
            "R1 reset outputs", {ale, rd_n, wr_n, ad_oe, busy, done}, 6'b011000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 0 && ale === 0, "R1 idle after reset", {busy, ale}, 0);

        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i][36], VEC[i][35], VEC[i][34:19], VEC[i][18:11],
                      int'(VEC[i][10:8]), VEC[i][7:0], 1'b0);
        end

        // R9: done lasts one clock
        @(negedge clk);
        chk(done === 1'b0, "R9 done one clock", done, 0);

        // R10: request while busy ignored
        run_cycle(1'b0, 1'b0, 16'h4321, 8'h00, 2, 8'h9D, 1'b1);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(ale === 1'b0 && busy === 1'b0, "R10 busy request ignored", {ale, busy}, 0);
        end

        // R10: request in the completion clock starts T1 next clock
        run_cycle(1'b1, 1'b0, 16'h2468, 8'h11, 0, 8'h00, 1'b0);
        req_valid = 1'b1; req_addr = 16'hC35A; req_write = 1'b0; req_io = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale === 1'b1 && ad_out === 8'h5A, "R10 back-to-back accept", ad_out, 8'h5A);
        chk(a_hi === 8'hC3, "R3 back-to-back upper", a_hi, 8'hC3);
        ad_in = 8'h77;
        repeat (3) @(negedge clk);                // T2, T3, done
        chk(done === 1'b1 && rdata === 8'h77, "R9/R7 back-to-back read", rdata, 8'h77);
        ad_in = 8'h00;

        // R1: reset in a wait state abandons the cycle
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0102; req_write = 1'b1; req_io = 1'b1;
        req_wdata = 8'hE7; bus_ready = 1'b0;
        @(negedge clk);                           // T1
        req_valid = 1'b0;
        repeat (3) @(negedge clk);                // T2, TW, TW
        chk(wr_n === 1'b0, "R6 still waiting", wr_n, 0);
        rst_n = 1'b0;
        #1;
        chk(wr_n === 1 && ad_oe === 0 && busy === 0 && io_m === 0, "R1 reset mid-cycle",
            {wr_n, ad_oe, busy, io_m}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1; bus_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 0 && done === 0, "R1 idle after mid-cycle reset", {busy, done}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule